// File: doc/BRIEF.md
# Snooping Line Controller for an Invalidate Protocol with an Exclusive State

This block keeps the coherence state and the four-word data block of one write-back cache line. A line is in one of four states: Invalid, Shared, Exclusive-clean or Dirty. The controller answers processor reads and writes. When it needs the shared bus it raises a request and names the transaction it wants. It also watches every transaction that other caches put on the bus.

On a read miss the controller fetches the block. It reads the bus "copy present" response at the grant to choose its new state. If another cache holds the block, the line becomes Shared; if not, it becomes Exclusive-clean. A later write to an Exclusive-clean line then needs no bus traffic. Writes to Shared lines broadcast an invalidate. When a Dirty line supplies a remote reader, memory is also told to take the data. Tag comparison, bus arbitration and memory lie outside the block: the surrounding logic reports whether the processor's block and the snooped block match the line through `cpu_match` and `snp_match`.

Bus transactions complete in the grant cycle. The fill data and the copy-present response are valid in that same cycle. A snooped transaction is presented for exactly one cycle, and the controller answers it combinationally in that cycle.

Top module: `snoop_line_ctrl`

## Requirements
- R1: A processor read that misses raises `bus_req` with command 0 (read). At the grant, the line takes `bus_fill_data`, where word i sits at bits [i*32 +: 32]. `cpu_ack` rises in that same cycle with the selected word on `cpu_rdata`. If `bus_present_in` is high, the state becomes 1 (Shared).
- R2: A matching snooped read (command 0) on a Dirty line (state 3) raises `snp_present`, `snp_supply` and `snp_mem_wr`, and puts the line's block on `snp_data`. The line ends in Shared.
- R3: A read miss granted with `bus_present_in` low leaves the line in state 2 (Exclusive-clean).
- R4: A write hit on a Shared line raises a bus request with command 2 (invalidate). At its grant the word is written, the line becomes Dirty and `cpu_ack` rises.
- R5: A write hit on an Exclusive-clean or Dirty line is acknowledged in the cycle it is presented, with no bus request. The word is written and the line becomes Dirty.
- R6: A write miss requests command 1 (read-for-ownership). At the grant, the block is filled with the written word merged in, and the line ends Dirty with no further bus transaction.
- R7: A miss that replaces a Dirty line first issues command 3 (write-back), with the line's block on `bus_wb_data`, and then fetches. A miss that replaces a Shared or Exclusive-clean line issues no write-back.
- R8: A matching snooped read on an Exclusive-clean or Shared line raises `snp_present` and `snp_supply`, keeps `snp_mem_wr` low, and leaves the line Shared.
- R9: A matching snooped read-for-ownership invalidates any valid line, and the line raises `snp_present` and `snp_supply`. A matching snooped invalidate also leaves the line Invalid; it supplies data only if the line was Dirty. In both cases `snp_mem_wr` is high exactly when the line was Dirty.
- R10: In any cycle with `snp_valid` high, the snoop is applied first. The processor gets no `cpu_ack` and a bus grant is not taken. A pending invalidate whose Shared line was lost to the snoop is reissued as a read-for-ownership.
- R11: A snoop with `snp_match` low, a snooped write-back (command 3), or any snoop of an Invalid line gives no response and leaves the state unchanged.
- R12: After reset the line is Invalid (state 0), and `bus_req` and `cpu_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Request is a write |
| cpu_match | input | 1 | Requested block is the one the line holds |
| cpu_word | input | 2 | Word index in the block |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_wb_data | output | 128 | Block written back |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_present_in | input | 1 | Another cache holds the fetched block |
| bus_fill_data | input | 128 | Block delivered at the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_match | input | 1 | Snooped block is the line's block |
| snp_present | output | 1 | Copy-present response |
| snp_supply | output | 1 | Line drives `snp_data` |
| snp_mem_wr | output | 1 | Memory must capture `snp_data` |
| snp_data | output | 128 | Block supplied cache-to-cache |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive-clean, 3 Dirty |

## Verification
A snooped transaction and a processor request can arrive in the same cycle. A snoop can also coincide with this line's own bus grant. The bench drives a read hit together with a snooped read-for-ownership. It expects no acknowledge in that cycle, an Invalid line afterwards, and a plain read miss next. It also holds a pending invalidate and delivers a snooped invalidate in the cycle of its grant. It expects the grant to be ignored, the request to come back as a read-for-ownership, and the written word to be merged into the fetched block.

// File: rtl/snoopx_pkg.sv
package snoopx_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHD = 2'd1,
        LN_EXC = 2'd2,
        LN_DTY = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_UPG = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WB    = 2'd1,
        PH_FETCH = 2'd2
    } phase_e;

    typedef struct packed {
        logic     present;
        logic     supply;
        logic     mem_wr;
        line_st_e nxt;
    } snp_resp_t;

    // Reaction of a valid matching line to another cache's transaction.
    function automatic snp_resp_t snoop_react(input line_st_e st, input bus_cmd_e cmd);
        snp_resp_t r;
        r.present = 1'b0;
        r.supply  = 1'b0;
        r.mem_wr  = 1'b0;
        r.nxt     = st;
        if (st != LN_INV) begin
            unique case (cmd)
                BC_RD: begin
                    r.present = 1'b1;
                    r.supply  = 1'b1;
                    r.mem_wr  = (st == LN_DTY);
                    r.nxt     = LN_SHD;
                end
                BC_RDX: begin
                    r.present = 1'b1;
                    r.supply  = 1'b1;
                    r.mem_wr  = (st == LN_DTY);
                    r.nxt     = LN_INV;
                end
                BC_UPG: begin
                    r.supply  = (st == LN_DTY);
                    r.mem_wr  = (st == LN_DTY);
                    r.nxt     = LN_INV;
                end
                default: ;
            endcase
        end
        return r;
    endfunction

    // State installed when an own fetch completes.
    function automatic line_st_e fill_state(input bus_cmd_e cmd, input logic others);
        if (cmd == BC_RD) begin
            return others ? LN_SHD : LN_EXC;
        end
        return LN_DTY;
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import snoopx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int BLK_W    = WORD_W * BLK_WORDS,
    localparam int IDX_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [BLK_W-1:0] blk
);

    for (genvar w = 0; w < BLK_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit_w;

        assign hit_w = wr_en && (wr_idx == IDX_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (hit_w) begin
                word_q <= wr_data;
            end else if (fill_en) begin
                word_q <= fill_blk[w*WORD_W +: WORD_W];
            end
        end

        assign blk[w*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
    import snoopx_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input  logic             snp_valid,
    input  logic             snp_match,
    input  bus_cmd_e         snp_cmd,
    input  line_st_e         st,
    input  logic [BLK_W-1:0] line_blk,
    output snp_resp_t        rsp,
    output logic             active,
    output logic [BLK_W-1:0] sup_data
);

    always_comb begin
        active = snp_valid && snp_match && (st != LN_INV);
        if (active) begin
            rsp = snoop_react(st, snp_cmd);
        end else begin
            rsp = '{present: 1'b0, supply: 1'b0, mem_wr: 1'b0, nxt: st};
        end
        sup_data = rsp.supply ? line_blk : '0;
    end

endmodule

// File: rtl/coh_req_seq.sv
module coh_req_seq
    import snoopx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cpu_req,
    input  logic     cpu_we,
    input  logic     cpu_match,
    input  line_st_e st,
    input  logic     snp_valid,
    input  logic     bus_gnt,
    input  logic     bus_present_in,
    output logic     bus_req,
    output bus_cmd_e bus_cmd,
    output logic     cpu_ack,
    output logic     ack_from_fill,
    output logic     st_we,
    output line_st_e st_nxt,
    output logic     fill_en,
    output logic     wr_en
);

    phase_e   ph_q, ph_d;
    bus_cmd_e pend_q, pend_d, eff_cmd;
    logic     hit, take;

    always_comb begin
        hit     = cpu_match && (st != LN_INV);
        // An invalidate whose shared copy was taken away must refetch.
        eff_cmd = (pend_q == BC_UPG && st != LN_SHD) ? BC_RDX : pend_q;
        take    = bus_gnt && !snp_valid;

        bus_req = 1'b0;
        bus_cmd = eff_cmd;
        if (ph_q == PH_WB && st == LN_DTY) begin
            bus_req = 1'b1;
            bus_cmd = BC_WB;
        end else if (ph_q == PH_FETCH) begin
            bus_req = 1'b1;
        end

        ph_d          = ph_q;
        pend_d        = pend_q;
        cpu_ack       = 1'b0;
        ack_from_fill = 1'b0;
        st_we         = 1'b0;
        st_nxt        = st;
        fill_en       = 1'b0;
        wr_en         = 1'b0;

        if (!snp_valid) begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (cpu_req) begin
                        if (hit && !cpu_we) begin
                            cpu_ack = 1'b1;
                        end else if (hit && st != LN_SHD) begin
                            cpu_ack = 1'b1;
                            wr_en   = 1'b1;
                            st_we   = 1'b1;
                            st_nxt  = LN_DTY;
                        end else if (hit) begin
                            pend_d = BC_UPG;
                            ph_d   = PH_FETCH;
                        end else begin
                            pend_d = cpu_we ? BC_RDX : BC_RD;
                            ph_d   = (st == LN_DTY) ? PH_WB : PH_FETCH;
                        end
                    end
                end
                PH_WB: begin
                    if (st != LN_DTY) begin
                        ph_d = PH_FETCH;
                    end else if (take) begin
                        st_we  = 1'b1;
                        st_nxt = LN_INV;
                        ph_d   = PH_FETCH;
                    end
                end
                PH_FETCH: begin
                    if (take) begin
                        cpu_ack       = 1'b1;
                        st_we         = 1'b1;
                        fill_en       = (eff_cmd != BC_UPG);
                        ack_from_fill = (eff_cmd != BC_UPG);
                        wr_en         = cpu_we;
                        st_nxt        = (eff_cmd == BC_UPG) ? LN_DTY
                                                            : fill_state(eff_cmd, bus_present_in);
                        ph_d          = PH_IDLE;
                    end
                end
                default: ph_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pend_q <= BC_RD;
        end else begin
            ph_q   <= ph_d;
            pend_q <= pend_d;
        end
    end

    AST_ACK_YIELDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> !cpu_ack);  // R10

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd == BC_WB) |-> st == LN_DTY);  // R7

    AST_GRANT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && ph_q == PH_FETCH) |=> ph_q == PH_FETCH);  // R10

endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
    import snoopx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int BLK_W    = WORD_W * BLK_WORDS,
    localparam int IDX_W    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_match,
    input  logic [IDX_W-1:0]  cpu_word,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [BLK_W-1:0]  bus_wb_data,
    input  logic              bus_gnt,
    input  logic              bus_present_in,
    input  logic [BLK_W-1:0]  bus_fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic              snp_match,
    output logic              snp_present,
    output logic              snp_supply,
    output logic              snp_mem_wr,
    output logic [BLK_W-1:0]  snp_data,
    output logic [1:0]        line_state
);

    line_st_e   st_q, seq_nxt;
    bus_cmd_e   seq_cmd;
    snp_resp_t  rsp;
    logic       snp_act, seq_we, fill_en, wr_en, from_fill;
    logic [BLK_W-1:0] line_blk, rd_src;

    coh_line_store #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_blk (bus_fill_data),
        .wr_en    (wr_en),
        .wr_idx   (cpu_word),
        .wr_data  (cpu_wdata),
        .blk      (line_blk)
    );

    coh_snoop_resp #(.BLK_W(BLK_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_match (snp_match),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .st        (st_q),
        .line_blk  (line_blk),
        .rsp       (rsp),
        .active    (snp_act),
        .sup_data  (snp_data)
    );

    coh_req_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .cpu_match      (cpu_match),
        .st             (st_q),
        .snp_valid      (snp_valid),
        .bus_gnt        (bus_gnt),
        .bus_present_in (bus_present_in),
        .bus_req        (bus_req),
        .bus_cmd        (seq_cmd),
        .cpu_ack        (cpu_ack),
        .ack_from_fill  (from_fill),
        .st_we          (seq_we),
        .st_nxt         (seq_nxt),
        .fill_en        (fill_en),
        .wr_en          (wr_en)
    );

    // Snoop transitions win; the sequencer never writes during a snoop.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LN_INV;
        end else if (snp_act) begin
            st_q <= rsp.nxt;
        end else if (seq_we) begin
            st_q <= seq_nxt;
        end
    end

    always_comb begin
        rd_src      = from_fill ? bus_fill_data : line_blk;
        cpu_rdata   = rd_src[cpu_word*WORD_W +: WORD_W];
        bus_cmd     = seq_cmd;
        bus_wb_data = line_blk;
        snp_present = rsp.present;
        snp_supply  = rsp.supply;
        snp_mem_wr  = rsp.mem_wr;
        line_state  = st_q;
    end

    AST_EXC_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_match && st_q == LN_EXC && !snp_valid)
            |-> (cpu_ack && !bus_req));  // R5

    AST_DIRTY_SHARE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_match && snp_cmd == 2'd0 && st_q == LN_DTY)
            |=> line_state == 2'd1);  // R2

    AST_DIRTY_SHARE_MEM: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_match && snp_cmd == 2'd0 && st_q == LN_DTY)
            |-> (snp_mem_wr && snp_supply && snp_present));  // R2

    AST_SNOOP_KILLS: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_match && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
            |=> line_state == 2'd0);  // R9

    AST_LONE_FILL_EXC: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt && !snp_valid && bus_cmd == 2'd0 && !bus_present_in)
            |=> line_state == 2'd2);  // R3

    AST_QUIET_SNOOP: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && (!snp_match || snp_cmd == 2'd3))
            |-> (!snp_present && !snp_supply && !snp_mem_wr));  // R11

endmodule

// File: tb/snoop_line_ctrl_test.sv
module snoop_line_ctrl_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        snoop;
        logic [1:0]  cmd;
        logic        we;
        logic        match;
        logic [1:0]  word;
        logic [31:0] wdata;
        logic        pres;
        logic [31:0] fbase;
        logic [1:0]  nbus;
        logic [1:0]  c1;
        logic [1:0]  c2;
        logic [1:0]  est;
        logic        chk;
        logic [31:0] edat;
        logic        ep;
        logic        es;
        logic        em;
        logic [3:0]  rq;
    } vec_t;

    // snoop cmd we match word wdata pres fbase nbus c1 c2 est chk edat ep es em rq
    localparam vec_t VECS [17] = '{
        '{0,0,0,0,1,0,0,'h100,1,0,0,2,1,'h101,0,0,0,3},      // R3 lone read miss
        '{0,0,1,1,2,'hAAAA,0,0,0,0,0,3,0,0,0,0,0,5},         // R5 quiet write
        '{0,0,0,1,2,0,0,0,0,0,0,3,1,'hAAAA,0,0,0,5},         // R5 word written
        '{1,0,0,1,2,0,0,0,0,0,0,1,1,'hAAAA,1,1,1,2},         // R2 dirty supplies
        '{0,0,1,1,0,'hBEEF,0,0,1,2,0,3,0,0,0,0,0,4},         // R4 invalidate
        '{1,2,0,1,0,0,0,0,0,0,0,0,1,'hBEEF,0,1,1,9},         // R9 snooped invalidate
        '{0,0,0,0,3,0,1,'h200,1,0,0,1,1,'h203,0,0,0,1},      // R1 shared fill
        '{1,0,0,1,3,0,0,0,0,0,0,1,1,'h203,1,1,0,8},          // R8 shared supplies
        '{1,1,0,1,3,0,0,0,0,0,0,0,1,'h203,1,1,0,9},          // R9 ownership snoop
        '{0,0,1,0,1,'h1111,1,'h300,1,1,0,3,0,0,0,0,0,6},     // R6 write miss
        '{0,0,0,1,1,0,0,0,0,0,0,3,1,'h1111,0,0,0,6},         // R6 merged word
        '{0,0,0,1,0,0,0,0,0,0,0,3,1,'h300,0,0,0,6},          // R6 filled word
        '{0,0,0,0,2,0,0,'h400,2,3,0,2,1,'h402,0,0,0,7},      // R7 dirty replace
        '{1,0,0,0,2,0,0,0,0,0,0,2,0,0,0,0,0,11},             // R11 no match
        '{1,0,0,1,2,0,0,0,0,0,0,1,1,'h402,1,1,0,8},          // R8 exclusive supplies
        '{0,0,0,0,0,0,0,'h500,1,0,0,2,1,'h500,0,0,0,7},      // R7 clean replace
        '{1,3,0,1,0,0,0,0,0,0,0,2,0,0,0,0,0,11}              // R11 write-back snoop
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0, cpu_we = 1'b0, cpu_match = 1'b0;
    logic [1:0]   cpu_word = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ack;
    logic [31:0]  cpu_rdata;
    logic         bus_req;
    logic [1:0]   bus_cmd;
    logic [127:0] bus_wb_data;
    logic         bus_gnt = 1'b0, bus_present_in = 1'b0;
    logic [127:0] bus_fill_data = '0;
    logic         snp_valid = 1'b0, snp_match = 1'b0;
    logic [1:0]   snp_cmd = '0;
    logic         snp_present, snp_supply, snp_mem_wr;
    logic [127:0] snp_data;
    logic [1:0]   line_state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    snoop_line_ctrl uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_match(cpu_match),
        .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_wb_data(bus_wb_data),
        .bus_gnt(bus_gnt), .bus_present_in(bus_present_in), .bus_fill_data(bus_fill_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_match(snp_match),
        .snp_present(snp_present), .snp_supply(snp_supply), .snp_mem_wr(snp_mem_wr),
        .snp_data(snp_data), .line_state(line_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] mkblk(input logic [31:0] base);
        logic [127:0] b;
        for (int i = 0; i < 4; i++) b[i*32 +: 32] = base + 32'(i);
        return b;
    endfunction

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic run_cpu(input vec_t v, output logic [127:0] wbd);
        int nb = 0;
        logic [1:0] cmds [2];
        logic got = 1'b0;
        logic [31:0] rd = '0;
        cmds[0] = '0; cmds[1] = '0; wbd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = v.we; cpu_match = v.match;
        cpu_word = v.word; cpu_wdata = v.wdata;
        for (int c = 0; c < 20 && !got; c++) begin
            #1;
            if (bus_req) begin
                if (nb < 2) cmds[nb] = bus_cmd;
                if (bus_cmd == 2'd3) wbd = bus_wb_data;
                nb++;
                bus_gnt = 1'b1; bus_present_in = v.pres; bus_fill_data = mkblk(v.fbase);
                #1;
            end
            if (cpu_ack) begin
                got = 1'b1;
                rd = cpu_rdata;
            end
            @(negedge clk);
            bus_gnt = 1'b0;
        end
        cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        check(got, v.rq, "request acknowledged", 128'(got), 1);
        check(nb == int'(v.nbus), v.rq, "bus transaction count", 128'(nb), 128'(v.nbus));
        if (nb >= 1 && v.nbus >= 1) check(cmds[0] == v.c1, v.rq, "first bus command", 128'(cmds[0]), 128'(v.c1));
        if (nb >= 2 && v.nbus >= 2) check(cmds[1] == v.c2, v.rq, "second bus command", 128'(cmds[1]), 128'(v.c2));
        if (v.chk) check(rd == v.edat, v.rq, "read data", 128'(rd), 128'(v.edat));
        check(line_state == v.est, v.rq, "state after request", 128'(line_state), 128'(v.est));
    endtask

    task automatic run_snoop(input vec_t v);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = v.cmd; snp_match = v.match;
        #1;
        check(snp_present == v.ep, v.rq, "copy present", 128'(snp_present), 128'(v.ep));
        check(snp_supply == v.es, v.rq, "supply", 128'(snp_supply), 128'(v.es));
        check(snp_mem_wr == v.em, v.rq, "memory update", 128'(snp_mem_wr), 128'(v.em));
        if (v.chk) check(snp_data[v.word*32 +: 32] == v.edat, v.rq, "supplied word",
                         128'(snp_data[v.word*32 +: 32]), 128'(v.edat));
        @(negedge clk);
        snp_valid = 1'b0; snp_match = 1'b0;
        #1;
        check(line_state == v.est, v.rq, "state after snoop", 128'(line_state), 128'(v.est));
    endtask

    function automatic vec_t cpu_vec(input logic we, input logic match, input logic [1:0] word,
                                     input logic [31:0] wdata, input logic pres,
                                     input logic [31:0] fbase, input logic [1:0] nbus,
                                     input logic [1:0] c1, input logic [1:0] c2,
                                     input logic [1:0] est, input logic chk,
                                     input logic [31:0] edat, input logic [3:0] rq);
        vec_t v = '0;
        v.we = we; v.match = match; v.word = word; v.wdata = wdata; v.pres = pres;
        v.fbase = fbase; v.nbus = nbus; v.c1 = c1; v.c2 = c2; v.est = est;
        v.chk = chk; v.edat = edat; v.rq = rq;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] wbd;
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        check(line_state == 2'd0, 12, "reset state", 128'(line_state), 0);
        check(!bus_req, 12, "no bus request after reset", 128'(bus_req), 0);
        check(!cpu_ack, 12, "no acknowledge after reset", 128'(cpu_ack), 0);

        for (int i = 0; i < 17; i++) begin
            if (VECS[i].snoop) run_snoop(VECS[i]);
            else run_cpu(VECS[i], wbd);
        end

        // R10 read hit and snooped ownership in the same cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_match = 1'b1; cpu_word = 2'd0;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_match = 1'b1;
        #1;
        check(!cpu_ack, 10, "processor held during snoop", 128'(cpu_ack), 0);
        check(snp_present, 10, "snoop answered first", 128'(snp_present), 1);
        @(negedge clk);
        snp_valid = 1'b0; snp_match = 1'b0; cpu_req = 1'b0;
        #1;
        check(line_state == 2'd0, 10, "line lost to snoop", 128'(line_state), 0);
        v = cpu_vec(0, 0, 2'd0, 0, 0, 'h600, 1, 0, 0, 2, 1, 'h600, 10);
        run_cpu(v, wbd);

        // R8 take the line to shared for the next case
        v = '0; v.snoop = 1; v.cmd = 0; v.match = 1; v.est = 1; v.ep = 1; v.es = 1; v.rq = 8;
        run_snoop(v);

        // R10 pending invalidate loses its copy in its grant cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_match = 1'b1; cpu_word = 2'd1; cpu_wdata = 32'h7777;
        @(negedge clk);
        #1;
        check(bus_req && bus_cmd == 2'd2, 4, "invalidate requested", 128'({bus_req, bus_cmd}), 128'(3'b110));
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_match = 1'b1;
        bus_gnt = 1'b1;
        #1;
        check(!cpu_ack, 10, "grant not taken during snoop", 128'(cpu_ack), 0);
        @(negedge clk);
        snp_valid = 1'b0; snp_match = 1'b0; bus_gnt = 1'b0;
        #1;
        check(bus_req && bus_cmd == 2'd1, 10, "reissued as ownership read",
              128'({bus_req, bus_cmd}), 128'(3'b101));
        bus_gnt = 1'b1; bus_present_in = 1'b1; bus_fill_data = mkblk('h800);
        #1;
        check(cpu_ack, 10, "write completes at grant", 128'(cpu_ack), 1);
        @(negedge clk);
        bus_gnt = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        #1;
        check(line_state == 2'd3, 6, "dirty after ownership fill", 128'(line_state), 3);
        v = cpu_vec(0, 1, 2'd1, 0, 0, 0, 0, 0, 0, 3, 1, 'h7777, 6);
        run_cpu(v, wbd);
        v = cpu_vec(0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 3, 1, 'h802, 6);
        run_cpu(v, wbd);

        // R7 write-back carries the dirty block
        v = cpu_vec(0, 0, 2'd3, 0, 0, 'h900, 2, 3, 0, 2, 1, 'h903, 7);
        run_cpu(v, wbd);
        check(wbd[63:32] == 32'h7777, 7, "written-back word", 128'(wbd[63:32]), 128'h7777);
        check(wbd[95:64] == 32'h802, 7, "written-back fill word", 128'(wbd[95:64]), 128'h802);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule